// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer/Counter

This block is a 16-bit up-counter with a small byte-wide register file and one external pin. A start field and a configuration byte turn it into one of several machines: a free-running interval timer, a timer launched (and optionally halted) by a pin edge, an edge counter on the pin, a gated counter that runs only while the pin sits at its active level, a pulse-width and period measurer, or a programmable pulse generator with a toggling output flip-flop. Two 16-bit registers, A and B, act as compare values. In pulse-width mode B also receives the captured value.

Software loads A and B one byte at a time, lower byte first. A new value reaches the compare logic only on the first source-clock tick after the upper byte arrives. The configuration byte is locked while the counter is started. The source clock is one of three prescaled tick enables supplied by the surrounding chip, or the rising edges of the pin. Everything runs in the single system clock domain, and the pin is synchronised before use.

Top module: `modeTimer16`

## Requirements
- R1: After reset, A and B read 0xFFFF, the counter reads 0, and both `irqPulse` and `ppgOut` are low.
- R2: Writing the lower byte of A (address 2) never changes the active A. After the upper byte (address 3) is written, the value {upper, lower} becomes active on the next source tick and not before.
- R3: Address 0 holds start[1:0] and autoCapture[2], and is always writable. Address 1 is the configuration byte {mode[7:6], clkSel[5:4], trigStop[3], singleEdge[2], oneShot[1], ffInit[0]}. It accepts writes only while start = 00. While start = 00 the counter is held at 0.
- R4: Writes to B (addresses 4 and 5) are ignored unless mode = 11.
- R5: In mode 00 with start = 01, `irqPulse` fires once every A source ticks, and the counter wraps to 0 at each match.
- R6: In mode 00 with clkSel = 11, start = 10 counts pin rising edges and start = 11 counts pin falling edges.
- R7: In mode 01, start = 10 counts source ticks only while the pin is high, and start = 11 counts them only while the pin is low.
- R8: In mode 00 with an internal clkSel and start = 10, the counter stays at 0 until a pin rising edge. With trigStop = 1, the following falling edge stops the counter and clears it. With trigStop = 0, counting continues.
- R9: In mode 10 with singleEdge = 1, B captures the number of source ticks the pin was high, and the counter then returns to 0.
- R10: In mode 10 with singleEdge = 0, B first captures the high time, then at the next rising edge captures the full period, and the count restarts.
- R11: In mode 11, `ppgOut` toggles when the count reaches B and again when it reaches A (with A > B). The level is A-B ticks on one side and B ticks on the other. While stopped, `ppgOut` equals ffInit.
- R12: In mode 11 with oneShot = 1 and start = 01, exactly one period is produced, with one interrupt and two output transitions, and the output comes to rest at its initial level.
- R13: With autoCapture set in mode 00 or 01, every counter increment also copies the new count into B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Byte write strobe |
| wrAddr | input | 3 | Write address (0 start, 1 config, 2/3 A low/high, 4/5 B low/high) |
| wrData | input | 8 | Write data byte |
| rdAddr | input | 3 | Read address (as write map, 6/7 counter low/high) |
| rdData | output | 8 | Read data byte, combinational from registers |
| prescTick | input | 3 | Prescaled tick enables, selected by clkSel 0 to 2 |
| pinIn | input | 1 | External pin: trigger, event, gate or clock |
| irqPulse | output | 1 | One-cycle interrupt on compare match or capture |
| ppgOut | output | 1 | Output flip-flop level |

## Verification
The assertions assume that software rewrites the configuration byte only after setting start to 00. They also assume the pin holds each level for at least two system clocks, so the synchroniser sees every edge. The stimulus stops the block before every reconfiguration and loads A and B while an internal tick runs every cycle. Every pin level is held for three cycles or more, and compare values are chosen so that A exceeds B in pulse-generator mode and A is large wherever a wrap would disturb a count.

// File: rtl/modeTimerPkg.sv
package modeTimerPkg;
  localparam int ByteW = 8;
  localparam int CntW  = 2 * ByteW;

  typedef enum logic [1:0] {
    ModeTimer  = 2'b00,
    ModeWindow = 2'b01,
    ModePulse  = 2'b10,
    ModePpg    = 2'b11
  } modeE;

  typedef enum logic [1:0] {
    StStop = 2'b00,
    StSoft = 2'b01,
    StRise = 2'b10,
    StFall = 2'b11
  } startE;

  typedef struct packed {
    modeE       mode;
    logic [1:0] clkSel;
    logic       trigStop;
    logic       singleEdge;
    logic       oneShot;
    logic       ffInit;
  } cfgT;

  typedef struct packed {
    logic tick;
    logic inc;
    logic clr;
    logic cmpEn;
    logic capture;
    logic snap;
    logic ffLoad;
    logic ppgEn;
    logic bWrOk;
  } strobeT;

  localparam logic [2:0] AddrStart = 3'd0;
  localparam logic [2:0] AddrCfg   = 3'd1;
  localparam logic [2:0] AddrALo   = 3'd2;
  localparam logic [2:0] AddrAHi   = 3'd3;
  localparam logic [2:0] AddrBLo   = 3'd4;
  localparam logic [2:0] AddrBHi   = 3'd5;
  localparam logic [2:0] AddrCLo   = 3'd6;
  localparam logic [2:0] AddrCHi   = 3'd7;
endpackage

// File: rtl/modeTimerReg.sv
module modeTimerReg
  import modeTimerPkg::*;
#(
  parameter int HalfW = ByteW
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrLo,
  input  logic               wrHi,
  input  logic [HalfW-1:0]   wrData,
  input  logic               tick,
  input  logic               capEn,
  input  logic [2*HalfW-1:0] capVal,
  output logic [2*HalfW-1:0] value
);
  localparam int FullW = 2 * HalfW;

  logic [HalfW-1:0] loHold;
  logic [FullW-1:0] stage;
  logic             pend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loHold <= '0;
      stage  <= '1;
      pend   <= 1'b0;
      value  <= '1;
    end else begin
      if (wrLo) loHold <= wrData;
      if (capEn) value <= capVal;
      else if (pend && tick) value <= stage;
      if (wrHi) begin
        stage <= {wrData, loHold};
        pend  <= 1'b1;
      end else if (pend && tick && !capEn) begin
        pend <= 1'b0;
      end
    end
  end

  // R2
  lo_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrLo && !wrHi && !pend && !capEn) |=> $stable(value));
endmodule

// File: rtl/modeTimerCtrl.sv
module modeTimerCtrl
  import modeTimerPkg::*;
#(
  parameter int NumPresc   = 3,
  parameter int SyncStages = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [2:0]          wrAddr,
  input  logic [ByteW-1:0]    wrData,
  input  logic [NumPresc-1:0] prescTick,
  input  logic                pinIn,
  input  logic                matchA,
  output cfgT                 cfg,
  output startE               startFld,
  output logic                autoCap,
  output strobeT              strb
);
  logic pinS, pinD, pinRise, pinFall;
  logic srcTick, actEdge, oppEdge, levelAct, evtSel;
  logic armed, phase, done;
  logic armedN, phaseN, doneN;
  logic stopOneShot;

  generate
    if (SyncStages > 1) begin : gSync
      logic [SyncStages-1:0] syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SyncStages-2:0], pinIn};
      end
      assign pinS = syncQ[SyncStages-1];
    end else begin : gSingle
      logic syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= 1'b0;
        else       syncQ <= pinIn;
      end
      assign pinS = syncQ;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinD <= 1'b0;
    else       pinD <= pinS;
  end

  assign pinRise  = pinS & ~pinD;
  assign pinFall  = ~pinS & pinD;
  assign actEdge  = (startFld == StFall) ? pinFall : pinRise;
  assign oppEdge  = (startFld == StFall) ? pinRise : pinFall;
  assign levelAct = (startFld == StFall) ? ~pinS : pinS;
  assign evtSel   = (cfg.clkSel == 2'(NumPresc));

  always_comb begin
    srcTick = pinRise;
    for (int i = 0; i < NumPresc; i++) begin
      if (cfg.clkSel == 2'(i)) srcTick = prescTick[i];
    end
  end

  // register writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startFld <= StStop;
      autoCap  <= 1'b0;
      cfg      <= '0;
    end else if (wrEn) begin
      if (wrAddr == AddrStart) begin
        startFld <= startE'(wrData[1:0]);
        autoCap  <= wrData[2];
      end
      if (wrAddr == AddrCfg && startFld == StStop) cfg <= cfgT'(wrData);
    end
  end

  // mode sequencing
  always_comb begin
    strb        = '0;
    strb.tick   = srcTick;
    strb.ffLoad = (startFld == StStop);
    strb.ppgEn  = (cfg.mode == ModePpg);
    strb.bWrOk  = (cfg.mode == ModePpg);
    strb.cmpEn  = (cfg.mode != ModePulse);
    strb.snap   = autoCap && (cfg.mode == ModeTimer || cfg.mode == ModeWindow);
    armedN = armed;
    phaseN = phase;
    doneN  = done;
    if (startFld == StStop) begin
      strb.clr = 1'b1;
      armedN   = 1'b0;
      phaseN   = 1'b0;
      doneN    = 1'b0;
    end else begin
      case (cfg.mode)
        ModeTimer: begin
          if (startFld == StSoft) begin
            strb.inc = srcTick;
          end else if (evtSel) begin
            strb.inc = actEdge;
          end else if (!armed) begin
            if (actEdge) begin
              armedN   = 1'b1;
              strb.clr = 1'b1;
            end
          end else begin
            strb.inc = srcTick;
            if (cfg.trigStop && oppEdge) begin
              armedN   = 1'b0;
              strb.clr = 1'b1;
            end
          end
        end
        ModeWindow: begin
          strb.inc = srcTick && (startFld == StSoft || levelAct);
        end
        ModePulse: begin
          if (!armed) begin
            if (actEdge) begin
              armedN   = 1'b1;
              phaseN   = 1'b0;
              strb.clr = 1'b1;
            end
          end else begin
            strb.inc = srcTick;
            if (!phase && oppEdge) begin
              strb.capture = 1'b1;
              if (cfg.singleEdge) begin
                armedN   = 1'b0;
                strb.clr = 1'b1;
              end else begin
                phaseN = 1'b1;
              end
            end else if (phase && actEdge) begin
              strb.capture = 1'b1;
              strb.clr     = 1'b1;
              phaseN       = 1'b0;
            end
          end
        end
        default: begin
          if (startFld == StSoft) begin
            strb.inc = srcTick && !done;
          end else if (!armed) begin
            if (actEdge) armedN = 1'b1;
          end else begin
            strb.inc = srcTick;
          end
        end
      endcase
    end
  end

  assign stopOneShot = matchA && cfg.oneShot && (cfg.mode == ModePpg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
      phase <= 1'b0;
      done  <= 1'b0;
    end else begin
      armed <= stopOneShot ? 1'b0 : armedN;
      phase <= phaseN;
      done  <= doneN | stopOneShot;
    end
  end

  // R3
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == AddrCfg && startFld != StStop) |=> $stable(cfg));

  // R12
  oneshot_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && cfg.mode == ModePpg && startFld == StSoft) |-> !strb.inc);
endmodule

// File: rtl/modeTimerData.sv
module modeTimerData
  import modeTimerPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [ByteW-1:0] wrData,
  input  strobeT           strb,
  input  logic             ffInit,
  output logic             matchA,
  output logic [CntW-1:0]  cnt,
  output logic [CntW-1:0]  regA,
  output logic [CntW-1:0]  regB,
  output logic             ffOut,
  output logic             irq
);
  logic [CntW-1:0] cntNext, capVal;
  logic            matchB, capEnB;
  logic            wrALo, wrAHi, wrBLo, wrBHi;

  assign cntNext = cnt + 1'b1;
  assign matchA  = strb.inc && strb.cmpEn && (cntNext == regA);
  assign matchB  = strb.inc && strb.cmpEn && (cntNext == regB);

  assign wrALo = wrEn && wrAddr == AddrALo;
  assign wrAHi = wrEn && wrAddr == AddrAHi;
  assign wrBLo = wrEn && wrAddr == AddrBLo && strb.bWrOk;
  assign wrBHi = wrEn && wrAddr == AddrBHi && strb.bWrOk;

  assign capEnB = strb.capture || (strb.snap && strb.inc);
  always_comb begin
    if (strb.capture) capVal = strb.inc ? cntNext : cnt;
    else              capVal = matchA ? '0 : cntNext;
  end

  modeTimerReg #(.HalfW(ByteW)) uRegA (
    .clk(clk), .rstN(rstN), .wrLo(wrALo), .wrHi(wrAHi), .wrData(wrData),
    .tick(strb.tick), .capEn(1'b0), .capVal('0), .value(regA)
  );

  modeTimerReg #(.HalfW(ByteW)) uRegB (
    .clk(clk), .rstN(rstN), .wrLo(wrBLo), .wrHi(wrBHi), .wrData(wrData),
    .tick(strb.tick), .capEn(capEnB), .capVal(capVal), .value(regB)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      ffOut <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (strb.clr)      cnt <= '0;
      else if (strb.inc) cnt <= matchA ? '0 : cntNext;
      irq <= matchA || strb.capture;
      if (strb.ffLoad)     ffOut <= ffInit;
      else if (strb.ppgEn) ffOut <= ffOut ^ matchA ^ matchB;
    end
  end

  // R11
  ff_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.ppgEn && !strb.ffLoad) |=> $stable(ffOut));
endmodule

// File: rtl/modeTimer16.sv
module modeTimer16
  import modeTimerPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [2:0] rdAddr,
  output logic [7:0] rdData,
  input  logic [2:0] prescTick,
  input  logic       pinIn,
  output logic       irqPulse,
  output logic       ppgOut
);
  cfgT             cfg;
  startE           startFld;
  logic            autoCap;
  strobeT          strb;
  logic            matchA;
  logic [CntW-1:0] cntVal, regA, regB;

  modeTimerCtrl #(.NumPresc(3), .SyncStages(2)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .prescTick(prescTick), .pinIn(pinIn), .matchA(matchA),
    .cfg(cfg), .startFld(startFld), .autoCap(autoCap), .strb(strb)
  );

  modeTimerData uData (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .ffInit(cfg.ffInit), .matchA(matchA), .cnt(cntVal),
    .regA(regA), .regB(regB), .ffOut(ppgOut), .irq(irqPulse)
  );

  always_comb begin
    case (rdAddr)
      AddrStart: rdData = {5'b0, autoCap, startFld};
      AddrCfg:   rdData = cfg;
      AddrALo:   rdData = regA[ByteW-1:0];
      AddrAHi:   rdData = regA[CntW-1:ByteW];
      AddrBLo:   rdData = regB[ByteW-1:0];
      AddrBHi:   rdData = regB[CntW-1:ByteW];
      AddrCLo:   rdData = cntVal[ByteW-1:0];
      default:   rdData = cntVal[CntW-1:ByteW];
    endcase
  end

  // R3
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startFld == StStop) |=> (cntVal == '0));
endmodule

// File: tb/modeTimer16_test.sv
module modeTimer16_test;
  logic       clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, pinIn = 1'b0;
  logic [2:0] wrAddr = '0, rdAddr = '0, prescTick = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       irqPulse, ppgOut;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  modeTimer16 uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .prescTick(prescTick), .pinIn(pinIn),
    .irqPulse(irqPulse), .ppgOut(ppgOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd16(input logic [2:0] a, output int v);
    logic [7:0] lo;
    rdAddr = a;          #1 lo = rdData;
    rdAddr = a + 3'd1;   #1 v = int'({rdData, lo});
  endtask

  function automatic logic [7:0] mk(input int md, input int cs, input bit ts,
                                    input bit se, input bit os, input bit fi);
    return {md[1:0], cs[1:0], ts, se, os, fi};
  endfunction

  task automatic setup(input logic [7:0] cfgByte, input int a, input int b);
    prescTick = 3'b001;
    wr(3'd0, 8'h00);
    wr(3'd1, cfgByte & 8'hCF);
    wr(3'd2, a[7:0]);
    wr(3'd3, a[15:8]);
    if (cfgByte[7:6] == 2'b11) begin
      wr(3'd4, b[7:0]);
      wr(3'd5, b[15:8]);
    end
    cycles(2);
    wr(3'd1, cfgByte);
  endtask

  task automatic irqGap(output int gap);
    int t = 0;
    while (!irqPulse && t < 300) begin @(negedge clk); t++; end
    gap = 0;
    do begin @(negedge clk); gap++; end while (!irqPulse && gap < 300);
  endtask

  task automatic ppgSpan(input logic first, output int len1, output int len2);
    int t = 0;
    while (ppgOut != first && t < 300) begin @(negedge clk); t++; end
    len1 = 0;
    while (ppgOut == first && len1 < 300) begin @(negedge clk); len1++; end
    len2 = 0;
    while (ppgOut != first && len2 < 300) begin @(negedge clk); len2++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v, v2, g, hi, lo, nIrq, nTog;
    logic prevP;
    cycles(3);
    rstN = 1'b1;
    cycles(1);
    // R1 reset state
    rd16(3'd2, v);  check(v == 16'hFFFF, "R1 A reset", v, 16'hFFFF);
    rd16(3'd4, v);  check(v == 16'hFFFF, "R1 B reset", v, 16'hFFFF);
    rd16(3'd6, v);  check(v == 0, "R1 counter reset", v, 0);
    check(!irqPulse && !ppgOut, "R1 outputs low", {irqPulse, ppgOut}, 0);

    // R5 interval sweep
    for (int a = 1; a <= 10; a++) begin
      setup(mk(0, 0, 0, 0, 0, 0), a, 0);
      wr(3'd0, 8'h01);
      irqGap(g);
      check(g == a, $sformatf("R5 irq interval A=%0d", a), g, a);
    end

    // R3 lock and stop-clear
    setup(mk(0, 0, 0, 0, 0, 0), 1000, 0);
    wr(3'd0, 8'h01);
    cycles(5);
    wr(3'd1, 8'hC3);
    rdAddr = 3'd1; #1;
    check(rdData == mk(0, 0, 0, 0, 0, 0), "R3 config locked", rdData, 0);
    wr(3'd0, 8'h00);
    cycles(1);
    rd16(3'd6, v); check(v == 0, "R3 stop clears counter", v, 0);

    // R2 byte-wise load
    setup(mk(0, 0, 0, 0, 0, 0), 16'h0100, 0);
    prescTick = 3'b000;
    wr(3'd2, 8'h34);
    rd16(3'd2, v); check(v == 16'h0100, "R2 lower byte alone", v, 16'h0100);
    wr(3'd3, 8'h12);
    rd16(3'd2, v); check(v == 16'h0100, "R2 before tick", v, 16'h0100);
    cycles(3);
    rd16(3'd2, v); check(v == 16'h0100, "R2 no tick no load", v, 16'h0100);
    @(negedge clk); prescTick = 3'b001;
    @(negedge clk); prescTick = 3'b000;
    rd16(3'd2, v); check(v == 16'h1234, "R2 load on tick", v, 16'h1234);
    prescTick = 3'b001;

    // R4 B locked outside PPG
    rd16(3'd4, v2);
    wr(3'd4, 8'h05); wr(3'd5, 8'h00);
    cycles(3);
    rd16(3'd4, v); check(v == v2, "R4 B ignored in mode 00", v, v2);

    // R13 auto-capture
    setup(mk(0, 0, 0, 0, 0, 0), 1000, 0);
    wr(3'd0, 8'h05);
    cycles(6);
    prescTick = 3'b000;
    cycles(2);
    rd16(3'd6, v); rd16(3'd4, v2);
    check(v == v2 && v != 0, "R13 B follows count", v2, v);
    prescTick = 3'b001;

    // R6 event counting
    setup(mk(0, 3, 0, 0, 0, 0), 1000, 0);
    wr(3'd0, 8'h02);
    cycles(3);
    repeat (5) begin pinIn = 1'b1; cycles(3); pinIn = 1'b0; cycles(3); end
    cycles(3);
    rd16(3'd6, v); check(v == 5, "R6 rising edges", v, 5);
    setup(mk(0, 3, 0, 0, 0, 0), 1000, 0);
    wr(3'd0, 8'h03);
    cycles(3);
    repeat (4) begin pinIn = 1'b1; cycles(3); pinIn = 1'b0; cycles(3); end
    cycles(3);
    rd16(3'd6, v); check(v == 4, "R6 falling edges", v, 4);

    // R7 window gating
    setup(mk(1, 0, 0, 0, 0, 0), 1000, 0);
    wr(3'd0, 8'h02);
    cycles(3);
    pinIn = 1'b1; cycles(7); pinIn = 1'b0; cycles(4);
    rd16(3'd6, v); check(v == 7, "R7 active-high window", v, 7);
    setup(mk(1, 0, 0, 0, 0, 0), 1000, 0);
    pinIn = 1'b1;
    wr(3'd0, 8'h03);
    cycles(3);
    pinIn = 1'b0; cycles(6); pinIn = 1'b1; cycles(4);
    rd16(3'd6, v); check(v == 6, "R7 active-low window", v, 6);
    pinIn = 1'b0;

    // R8 trigger start/stop
    setup(mk(0, 0, 1, 0, 0, 0), 1000, 0);
    wr(3'd0, 8'h02);
    cycles(5);
    rd16(3'd6, v); check(v == 0, "R8 waits for edge", v, 0);
    pinIn = 1'b1; cycles(6);
    rd16(3'd6, v); check(v > 0, "R8 counting after edge", v, 1);
    pinIn = 1'b0; cycles(5);
    rd16(3'd6, v); check(v == 0, "R8 stop edge clears", v, 0);
    setup(mk(0, 0, 0, 0, 0, 0), 1000, 0);
    wr(3'd0, 8'h02);
    cycles(3);
    pinIn = 1'b1; cycles(4); pinIn = 1'b0; cycles(5);
    rd16(3'd6, v); cycles(3); rd16(3'd6, v2);
    check(v2 == v + 3 && v > 0, "R8 start-only keeps running", v2, v + 3);

    // R9 single-edge pulse width sweep
    for (int w = 2; w <= 6; w++) begin
      setup(mk(2, 0, 0, 1, 0, 0), 16'hFFFF, 0);
      wr(3'd0, 8'h02);
      cycles(3);
      pinIn = 1'b1; cycles(w); pinIn = 1'b0; cycles(5);
      rd16(3'd4, v); check(v == w, $sformatf("R9 width %0d", w), v, w);
      rd16(3'd6, v); check(v == 0, "R9 counter cleared", v, 0);
    end

    // R10 double-edge width then period
    setup(mk(2, 0, 0, 0, 0, 0), 16'hFFFF, 0);
    wr(3'd0, 8'h02);
    cycles(3);
    pinIn = 1'b1; cycles(4); pinIn = 1'b0; cycles(5);
    rd16(3'd4, v); check(v == 4, "R10 high time", v, 4);
    cycles(3); pinIn = 1'b1; cycles(5);
    rd16(3'd4, v); check(v == 12, "R10 period", v, 12);
    pinIn = 1'b0;

    // R11 PPG sweep
    for (int a = 2; a <= 7; a++) begin
      for (int b = 1; b < a; b++) begin
        setup(mk(3, 0, 0, 0, 0, 0), a, b);
        wr(3'd0, 8'h01);
        ppgSpan(1'b1, hi, lo);
        check(hi == a - b, $sformatf("R11 high A=%0d B=%0d", a, b), hi, a - b);
        check(lo == b, $sformatf("R11 low A=%0d B=%0d", a, b), lo, b);
      end
    end
    setup(mk(3, 0, 0, 0, 0, 1), 6, 2);
    cycles(1);
    check(ppgOut == 1'b1, "R11 idle level from ffInit", ppgOut, 1);
    wr(3'd0, 8'h01);
    ppgSpan(1'b0, lo, hi);
    check(lo == 4, "R11 inverted low span", lo, 4);
    check(hi == 2, "R11 inverted high span", hi, 2);

    // R12 one-shot
    setup(mk(3, 0, 0, 0, 1, 0), 5, 2);
    wr(3'd0, 8'h01);
    nIrq = 0; nTog = 0; prevP = ppgOut;
    repeat (40) begin
      @(negedge clk);
      if (irqPulse) nIrq++;
      if (ppgOut != prevP) nTog++;
      prevP = ppgOut;
    end
    check(nIrq == 1, "R12 single interrupt", nIrq, 1);
    check(nTog == 2, "R12 two transitions", nTog, 2);
    check(ppgOut == 1'b0, "R12 rests at initial level", ppgOut, 0);
    wr(3'd0, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule